// File: doc/BRIEF.md
# Runahead retirement controller

This block sits at the retirement end of a small in-order instruction window, which is held as a circular buffer of instruction records. Entries are allocated at the tail. Execution results come back for any slot by index. Normally the oldest entry retires once its result is present, and a destination register is written at that point. If the oldest entry is a load that has come back flagged as a last-level cache miss, the block does not stall. Instead it copies the whole register file into a checkpoint and switches into runahead mode.

In runahead mode, results only go into a working copy of the register file. Reads through the architectural port come from the checkpoint. Each register carries a poison bit. The destination of the missing load is poisoned on entry. Any entry that reads a poisoned register, or any load that misses again, poisons its own destination. The oldest entry is removed at once if it is poisoned. Otherwise it is removed when its result arrives. Each removal frees a window slot, so younger work keeps flowing and can generate useful memory traffic.

When the original miss returns, the block leaves runahead mode in a single cycle. It restores the registers from the checkpoint, clears every poison bit and flushes the window down to the missing load alone. That load then retires with the returned data.

Top module: `runahead_retire`

## Requirements
- R1: Runahead mode (mode_o = 1) begins on the clock edge at which the oldest window entry, in normal mode, is a completed load (op code 1) whose completion carried the miss flag. No other condition causes it.
- R2: On entry, every register is copied into a checkpoint. While runahead mode lasts, rd_data_o returns the checkpoint value of the addressed register.
- R3: No result produced during runahead mode changes the value seen on rd_data_o for any register.
- R4: On the entry edge, the poison bit of the missing load's destination register is set (visible on rd_inv_o).
- R5: In runahead mode, an entry is poisoned if either of its source registers is poisoned, or if it is a load whose completion carried the miss flag. Removing a poisoned ALU (op 0) or load entry sets its destination's poison bit. Removing an unpoisoned one clears that bit.
- R6: In runahead mode, only the oldest entry is considered on each edge. A poisoned oldest entry is removed without waiting for completion. An unpoisoned one waits until it is completed. Each removal adds exactly one to pr_count_o.
- R7: alloc_ready_o is low while the window holds DEPTH entries. Removals in runahead mode free slots, so allocation can resume.
- R8: Removing an unpoisoned branch (op 2) whose completion carried the mispredict flag raises recover_o for one cycle. This applies in either mode. A poisoned branch never raises it.
- R9: On a miss return in runahead mode, the next cycle shows mode_o = 0, all registers equal to their checkpoint values and all poison bits clear. The window holds only the missing load, which retires on the following edge and writes the returned data to its destination.
- R10: In the cycle a miss return arrives in runahead mode, the exit takes priority. No entry is removed, pr_count_o keeps its value, and alloc_ready_o is low.
- R11: After reset, mode_o is 0, pr_count_o is 0, alloc_ready_o is 1, and every register reads 0 with its poison bit clear.
- R12: In normal mode, entries retire strictly oldest first, each only once completed. A retiring ALU or load entry writes its result to its destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Request to allocate an entry at the tail |
| alloc_op_i | input | 2 | Operation: 0 ALU, 1 load, 2 branch |
| alloc_dst_i | input | RW | Destination register index |
| alloc_src_a_i | input | RW | First source register index |
| alloc_src_b_i | input | RW | Second source register index |
| alloc_ready_o | output | 1 | Allocation accepted this cycle |
| alloc_idx_o | output | IW | Slot index the next allocation takes |
| cpl_valid_i | input | 1 | Execution result for a slot |
| cpl_idx_i | input | IW | Slot being completed |
| cpl_data_i | input | DW | Result value |
| cpl_miss_i | input | 1 | Load missed in the last-level cache |
| cpl_mispred_i | input | 1 | Branch was mispredicted |
| miss_ret_i | input | 1 | Data for the blocking miss has returned |
| miss_ret_data_i | input | DW | Returned load data |
| rd_addr_i | input | RW | Register read address |
| rd_data_o | output | DW | Architectural value of the addressed register |
| rd_inv_o | output | 1 | Poison bit of the addressed register |
| mode_o | output | 1 | 1 while in runahead mode |
| pr_count_o | output | CW | Running count of runahead removals |
| recover_o | output | 1 | One-cycle recovery request for a mispredicted branch |

## Verification
The assertions assume that allocation is requested only while alloc_ready_o is high. They also assume that a completion names a slot that currently holds an entry, is given once per entry, and never lands on the oldest entry in the same edge that removes it. Finally, they assume a miss return is given only in runahead mode. The bench keeps to these conditions by driving every request from tasks, which allocate only when space is known to exist and complete only slot indices captured from alloc_idx_o. It raises miss_ret_i only after mode_o has been seen high.

// File: rtl/runahead_pkg.sv
package runahead_pkg;
  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_BRANCH = 2'd2
  } op_e;
endpackage

// File: rtl/ra_window.sv
module ra_window
  import runahead_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RW    = 3,
  parameter int DW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  op_e           push_op_i,
  input  logic [RW-1:0] push_dst_i,
  input  logic [RW-1:0] push_sa_i,
  input  logic [RW-1:0] push_sb_i,
  input  logic          pop_i,
  input  logic          cpl_valid_i,
  input  logic [IW-1:0] cpl_idx_i,
  input  logic [DW-1:0] cpl_data_i,
  input  logic          cpl_miss_i,
  input  logic          cpl_mispred_i,
  input  logic          rewind_i,
  input  logic [IW-1:0] rewind_idx_i,
  input  logic [RW-1:0] rewind_dst_i,
  input  logic [DW-1:0] rewind_data_i,
  output logic [IW-1:0] tail_o,
  output logic [IW-1:0] head_idx_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output op_e           h_op_o,
  output logic [RW-1:0] h_dst_o,
  output logic [RW-1:0] h_sa_o,
  output logic [RW-1:0] h_sb_o,
  output logic [DW-1:0] h_data_o,
  output logic          h_done_o,
  output logic          h_miss_o,
  output logic          h_mispred_o
);
  op_e           op_q      [DEPTH];
  logic [RW-1:0] dst_q     [DEPTH];
  logic [RW-1:0] sa_q      [DEPTH];
  logic [RW-1:0] sb_q      [DEPTH];
  logic [DW-1:0] data_q    [DEPTH];
  logic          done_q    [DEPTH];
  logic          miss_q    [DEPTH];
  logic          mispred_q [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i]      <= OP_ALU;
        dst_q[i]     <= '0;
        sa_q[i]      <= '0;
        sb_q[i]      <= '0;
        data_q[i]    <= '0;
        done_q[i]    <= 1'b0;
        miss_q[i]    <= 1'b0;
        mispred_q[i] <= 1'b0;
      end
    end else begin
      if (cpl_valid_i) begin
        done_q[cpl_idx_i]    <= 1'b1;
        data_q[cpl_idx_i]    <= cpl_data_i;
        miss_q[cpl_idx_i]    <= cpl_miss_i;
        mispred_q[cpl_idx_i] <= cpl_mispred_i;
      end
      if (push_i) begin
        op_q[tail_q]      <= push_op_i;
        dst_q[tail_q]     <= push_dst_i;
        sa_q[tail_q]      <= push_sa_i;
        sb_q[tail_q]      <= push_sb_i;
        done_q[tail_q]    <= 1'b0;
        miss_q[tail_q]    <= 1'b0;
        mispred_q[tail_q] <= 1'b0;
        tail_q            <= nxt(tail_q);
      end
      if (pop_i) head_q <= nxt(head_q);
      if (rewind_i) begin
        // window shrinks to the blocking load, now completed with returned data
        head_q                  <= rewind_idx_i;
        tail_q                  <= nxt(rewind_idx_i);
        op_q[rewind_idx_i]      <= OP_LOAD;
        dst_q[rewind_idx_i]     <= rewind_dst_i;
        data_q[rewind_idx_i]    <= rewind_data_i;
        done_q[rewind_idx_i]    <= 1'b1;
        miss_q[rewind_idx_i]    <= 1'b0;
        mispred_q[rewind_idx_i] <= 1'b0;
        cnt_q                   <= CW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      end
    end
  end

  assign tail_o      = tail_q;
  assign head_idx_o  = head_q;
  assign count_o     = cnt_q;
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign h_op_o      = op_q[head_q];
  assign h_dst_o     = dst_q[head_q];
  assign h_sa_o      = sa_q[head_q];
  assign h_sb_o      = sb_q[head_q];
  assign h_data_o    = data_q[head_q];
  assign h_done_o    = done_q[head_q];
  assign h_miss_o    = miss_q[head_q];
  assign h_mispred_o = mispred_q[head_q];

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          inv_set_i,
  input  logic          inv_clr_i,
  input  logic          inv_flush_i,
  input  logic          ckpt_take_i,
  input  logic          ckpt_restore_i,
  input  logic [RW-1:0] src_a_i,
  input  logic [RW-1:0] src_b_i,
  output logic          src_inv_o,
  input  logic          arch_sel_i,
  input  logic [RW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_inv_o
);
  logic [DW-1:0]   rf_q [NREG];
  logic [DW-1:0]   ck_q [NREG];
  logic [NREG-1:0] inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q <= '0;
      for (int i = 0; i < NREG; i++) begin
        rf_q[i] <= '0;
        ck_q[i] <= '0;
      end
    end else begin
      if (ckpt_take_i)
        for (int i = 0; i < NREG; i++) ck_q[i] <= rf_q[i];
      if (ckpt_restore_i) begin
        for (int i = 0; i < NREG; i++) rf_q[i] <= ck_q[i];
      end else if (wr_en_i) begin
        rf_q[wr_addr_i] <= wr_data_i;
      end
      if (inv_flush_i)    inv_q            <= '0;
      else if (inv_set_i) inv_q[wr_addr_i] <= 1'b1;
      else if (inv_clr_i) inv_q[wr_addr_i] <= 1'b0;
    end
  end

  assign src_inv_o = inv_q[src_a_i] | inv_q[src_b_i];
  assign rd_data_o = arch_sel_i ? ck_q[rd_addr_i] : rf_q[rd_addr_i];
  assign rd_inv_o  = inv_q[rd_addr_i];

  assert_inv_clear_normal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arch_sel_i |-> (inv_q == '0));
  assert_ckpt_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ckpt_take_i && ckpt_restore_i));
endmodule

// File: rtl/runahead_retire.sv
module runahead_retire
  import runahead_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int CW    = 16,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_valid_i,
  input  logic [1:0]    alloc_op_i,
  input  logic [RW-1:0] alloc_dst_i,
  input  logic [RW-1:0] alloc_src_a_i,
  input  logic [RW-1:0] alloc_src_b_i,
  output logic          alloc_ready_o,
  output logic [IW-1:0] alloc_idx_o,
  input  logic          cpl_valid_i,
  input  logic [IW-1:0] cpl_idx_i,
  input  logic [DW-1:0] cpl_data_i,
  input  logic          cpl_miss_i,
  input  logic          cpl_mispred_i,
  input  logic          miss_ret_i,
  input  logic [DW-1:0] miss_ret_data_i,
  input  logic [RW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_inv_o,
  output logic          mode_o,
  output logic [CW-1:0] pr_count_o,
  output logic          recover_o
);
  logic          mode_q, recover_q;
  logic [CW-1:0] pr_q;
  logic [IW-1:0] miss_slot_q;
  logic [RW-1:0] miss_dst_q;

  logic          push, pop, enter, leave, pr_inc, rec_d;
  logic          wr_en, inv_set, inv_clr, src_inv, poison;
  logic          empty, full;
  logic [NW-1:0] win_cnt;
  logic [IW-1:0] head_idx;
  op_e           h_op;
  logic [RW-1:0] h_dst, h_sa, h_sb;
  logic [DW-1:0] h_data;
  logic          h_done, h_miss, h_mispred;

  assign alloc_ready_o = !full && !(mode_q && miss_ret_i);
  assign push          = alloc_valid_i && alloc_ready_o;

  ra_window #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) u_win (
    .clk_i, .rst_ni,
    .push_i(push), .push_op_i(op_e'(alloc_op_i)), .push_dst_i(alloc_dst_i),
    .push_sa_i(alloc_src_a_i), .push_sb_i(alloc_src_b_i),
    .pop_i(pop),
    .cpl_valid_i, .cpl_idx_i, .cpl_data_i, .cpl_miss_i, .cpl_mispred_i,
    .rewind_i(leave), .rewind_idx_i(miss_slot_q), .rewind_dst_i(miss_dst_q),
    .rewind_data_i(miss_ret_data_i),
    .tail_o(alloc_idx_o), .head_idx_o(head_idx), .empty_o(empty), .full_o(full),
    .count_o(win_cnt), .h_op_o(h_op), .h_dst_o(h_dst), .h_sa_o(h_sa), .h_sb_o(h_sb),
    .h_data_o(h_data), .h_done_o(h_done), .h_miss_o(h_miss), .h_mispred_o(h_mispred)
  );

  ra_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(h_dst), .wr_data_i(h_data),
    .inv_set_i(inv_set), .inv_clr_i(inv_clr), .inv_flush_i(leave),
    .ckpt_take_i(enter), .ckpt_restore_i(leave),
    .src_a_i(h_sa), .src_b_i(h_sb), .src_inv_o(src_inv),
    .arch_sel_i(mode_q), .rd_addr_i, .rd_data_o, .rd_inv_o
  );

  assign poison = src_inv || (h_op == OP_LOAD && h_done && h_miss);

  always_comb begin
    pop = 1'b0; enter = 1'b0; leave = 1'b0; pr_inc = 1'b0; rec_d = 1'b0;
    wr_en = 1'b0; inv_set = 1'b0; inv_clr = 1'b0;
    if (!mode_q) begin
      if (!empty && h_done) begin
        pop = 1'b1;
        if (h_op == OP_LOAD && h_miss) begin
          enter   = 1'b1;
          inv_set = 1'b1;
        end else begin
          wr_en = (h_op != OP_BRANCH);
          rec_d = (h_op == OP_BRANCH) && h_mispred;
        end
      end
    end else if (miss_ret_i) begin
      leave = 1'b1;  // exit wins over any removal this cycle
    end else if (!empty) begin
      if (poison) begin
        pop     = 1'b1;
        pr_inc  = 1'b1;
        inv_set = (h_op != OP_BRANCH);
      end else if (h_done) begin
        pop     = 1'b1;
        pr_inc  = 1'b1;
        wr_en   = (h_op != OP_BRANCH);
        inv_clr = (h_op != OP_BRANCH);
        rec_d   = (h_op == OP_BRANCH) && h_mispred;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b0;
      recover_q   <= 1'b0;
      pr_q        <= '0;
      miss_slot_q <= '0;
      miss_dst_q  <= '0;
    end else begin
      recover_q <= rec_d;
      pr_q      <= pr_q + CW'(pr_inc);
      if (enter) begin
        mode_q      <= 1'b1;
        miss_slot_q <= head_idx;
        miss_dst_q  <= h_dst;
      end else if (leave) begin
        mode_q <= 1'b0;
      end
    end
  end

  assign mode_o     = mode_q;
  assign pr_count_o = pr_q;
  assign recover_o  = recover_q;

  assert_entry_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(!empty && h_done && h_op == OP_LOAD && h_miss));
  assert_arch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !miss_ret_i) |=> ((rd_addr_i != $past(rd_addr_i)) || $stable(rd_data_o)));
  assert_exit_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && miss_ret_i) |=> (!mode_q && win_cnt == NW'(1)));
  assert_exit_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && miss_ret_i) |=> $stable(pr_count_o));
  assert_pr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pr_count_o == $past(pr_count_o) || pr_count_o == $past(pr_count_o) + 1'b1));
endmodule

// File: tb/runahead_retire_test.sv
`timescale 1ns/1ps
module runahead_retire_test;
  localparam int OPA = 0, OPL = 1, OPB = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       alloc_valid = 0;
  logic [1:0] alloc_op = 0;
  logic [2:0] alloc_dst = 0, alloc_sa = 0, alloc_sb = 0;
  logic       alloc_ready;
  logic [1:0] alloc_idx;
  logic       cpl_valid = 0;
  logic [1:0] cpl_idx = 0;
  logic [7:0] cpl_data = 0;
  logic       cpl_miss = 0, cpl_mispred = 0;
  logic       miss_ret = 0;
  logic [7:0] miss_ret_data = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       rd_inv, mode;
  logic [15:0] pr_count;
  logic       recover;

  int n_chk = 0, n_fail = 0, rec_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  runahead_retire uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_op_i(alloc_op), .alloc_dst_i(alloc_dst),
    .alloc_src_a_i(alloc_sa), .alloc_src_b_i(alloc_sb),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .cpl_valid_i(cpl_valid), .cpl_idx_i(cpl_idx), .cpl_data_i(cpl_data),
    .cpl_miss_i(cpl_miss), .cpl_mispred_i(cpl_mispred),
    .miss_ret_i(miss_ret), .miss_ret_data_i(miss_ret_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_inv_o(rd_inv),
    .mode_o(mode), .pr_count_o(pr_count), .recover_o(recover)
  );

  always @(posedge clk) if (rst_n && recover) rec_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic alloc(input int op, input int dst, input int a, input int b, output int idx);
    alloc_valid = 1; alloc_op = 2'(op); alloc_dst = 3'(dst); alloc_sa = 3'(a); alloc_sb = 3'(b);
    #0.1 idx = int'(alloc_idx);
    tick();
    alloc_valid = 0;
  endtask

  task automatic cpl(input int idx, input int data, input bit miss, input bit misp);
    cpl_valid = 1; cpl_idx = 2'(idx); cpl_data = 8'(data); cpl_miss = miss; cpl_mispred = misp;
    tick();
    cpl_valid = 0; cpl_miss = 0; cpl_mispred = 0;
  endtask

  task automatic chk_reg(input string req, input int r, input int exp);
    rd_addr = 3'(r); #0.1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic chk_inv(input string req, input int r, input int exp);
    rd_addr = 3'(r); #0.1;
    chk(req, int'(rd_inv), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ia, ib, iL, i2, i3, iB, iV, i5, i6, i7, ix;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11 reset state
    chk("R11 mode", int'(mode), 0);
    chk("R11 pr_count", int'(pr_count), 0);
    chk("R11 alloc_ready", int'(alloc_ready), 1);
    for (int r = 0; r < 8; r++) begin
      chk_reg("R11 reg", r, 0);
      chk_inv("R11 inv", r, 0);
    end

    // R12 normal retirement sweep: reg r <- r*3+1
    for (int r = 0; r < 8; r++) begin
      alloc(OPA, r, 0, 0, ix);
      cpl(ix, r * 3 + 1, 0, 0);
      tick();
    end
    for (int r = 0; r < 8; r++) chk_reg("R12 sweep", r, r * 3 + 1);

    // R12 oldest first: younger completes first but must wait
    alloc(OPA, 0, 0, 0, ia);
    alloc(OPA, 0, 0, 0, ib);
    cpl(ib, 50, 0, 0);
    tick(); tick();
    chk_reg("R12 wait for oldest", 0, 1);
    cpl(ia, 60, 0, 0);
    tick();
    chk_reg("R12 older first", 0, 60);
    tick();
    chk_reg("R12 younger second", 0, 50);
    alloc(OPA, 0, 0, 0, ix);
    cpl(ix, 1, 0, 0);
    tick();
    chk_reg("R12 restore r0", 0, 1);

    // R8 mispredicted branch in normal mode
    alloc(OPB, 0, 0, 0, ix);
    cpl(ix, 0, 0, 1);
    tick(); tick();
    chk("R8 normal recover", rec_cnt, 1);

    // Fill window: miss load, dependent, independent, dependent branch
    alloc(OPL, 1, 0, 0, iL);
    alloc(OPA, 2, 1, 0, i2);
    alloc(OPA, 3, 4, 5, i3);
    alloc(OPB, 0, 2, 2, iB);
    chk("R7 full stalls alloc", int'(alloc_ready), 0);
    cpl(iL, 0, 1, 0);
    chk("R1 not before head sees miss", int'(mode), 0);
    tick();
    chk("R1 enter runahead", int'(mode), 1);
    chk_inv("R4 load dst poisoned", 1, 1);
    chk_reg("R2 checkpoint read r1", 1, 4);
    chk("R7 slot freed", int'(alloc_ready), 1);
    chk("R6 no count at entry", int'(pr_count), 0);
    tick();
    chk("R6 poisoned removed at once", int'(pr_count), 1);
    chk_inv("R5 dependent poisoned", 2, 1);
    tick(); tick();
    chk("R6 valid head waits", int'(pr_count), 1);
    cpl(i3, 85, 0, 0);
    tick();
    chk("R6 valid removed after completion", int'(pr_count), 2);
    chk_inv("R5 valid result clears", 3, 0);
    chk_reg("R3 arch r3 held", 3, 10);
    tick();
    chk("R6 poisoned branch removed", int'(pr_count), 3);
    tick();
    chk("R8 poisoned branch no recover", rec_cnt, 1);

    alloc(OPB, 0, 4, 4, iV);
    cpl(iV, 0, 0, 1);
    tick(); tick();
    chk("R8 runahead valid branch recover", rec_cnt, 2);
    chk("R6 count after branch", int'(pr_count), 4);

    alloc(OPL, 5, 0, 0, i5);
    cpl(i5, 0, 1, 0);
    tick();
    chk_inv("R5 runahead miss poisons", 5, 1);
    chk_reg("R3 arch r5 held", 5, 16);
    alloc(OPA, 6, 3, 0, i6);
    cpl(i6, 119, 0, 0);
    tick();
    chk_inv("R5 valid source stays valid", 6, 0);
    chk_reg("R3 arch r6 held", 6, 19);
    chk("R6 count before exit", int'(pr_count), 6);

    // R10 exit in the cycle a poisoned head would go
    alloc(OPA, 7, 2, 2, i7);
    miss_ret = 1; miss_ret_data = 8'hA5;
    #0.1 chk("R10 alloc blocked on exit", int'(alloc_ready), 0);
    tick();
    miss_ret = 0;
    chk("R9 mode cleared", int'(mode), 0);
    chk("R10 no removal on exit", int'(pr_count), 6);
    for (int r = 0; r < 8; r++) begin
      chk_reg("R9 restored", r, r * 3 + 1);
      chk_inv("R9 inv cleared", r, 0);
    end
    tick();
    chk_reg("R9 load retires with return", 1, 165);
    chk("R9 window drained", int'(alloc_ready), 1);
    tick();
    chk("R8 total recovers", rec_cnt, 2);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule